// File: doc/BRIEF.md
# Sectioned Performance Counter Unit

This block is a profiling unit that sits on a simple word-addressed register bus. It holds one global counter pair and a configurable number of section counter pairs, from one to seven. Each pair has a 64-bit cycle counter and a 32-bit event counter. Software starts, stops and clears the pairs by writing particular values to particular word offsets, and reads the counts back through the same port.

The global pair opens a measurement window. A section pair counts cycles only while both the section itself and the global pair are running, so code regions can be timed within a window that software controls globally. Each event counter records how many times its pair went from stopped to running.

Pair `n` (pair 0 is the global pair, pairs 1 to `N_SECT` are sections) owns word offsets `4n` to `4n+3`. Reads return data one cycle after the read strobe.

Top module: `perf_section_counter`

## Requirements
- R1: After reset every cycle counter and event counter is zero, every pair is stopped, and `rdata_o` is zero.
- R2: A write of the value 0 to offset `4n+1` starts pair `n`; a write of any non-zero value there has no effect.
- R3: A write with bit 0 clear to offset `4n` stops pair `n`; its counts then hold their values.
- R4: The global cycle counter increases by one on each clock edge at which the global pair is running; a pair started at edge E0 and stopped at edge Es has counted Es-E0 cycles.
- R5: A section cycle counter increases by one on each clock edge at which both that section and the global pair are running, and holds otherwise.
- R6: An event counter increases by one on each stopped-to-running transition of its pair; a start write to a pair that is already running leaves the event count unchanged.
- R7: A write with bit 0 set to offset 0 clears every cycle counter and event counter in the unit and leaves all pairs stopped.
- R8: A write with bit 0 set to offset `4n` with `n` from 1 to `N_SECT` clears only that section's counters and stops it; other pairs are unaffected.
- R9: A read strobe at offset `4n` returns cycle bits 31:0, at `4n+1` cycle bits 63:32, and at `4n+2` the event count of pair `n`, on `rdata_o` in the cycle after the strobe; `rdata_o` holds between reads.
- R10: Reads of offset `4n+3`, or of any offset at or above `4*(N_SECT+1)`, return zero, and writes to those offsets or to `4n+2` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe, one word per cycle |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Word offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data, valid one cycle after `rd_en_i` |

## Verification
The assertions check on every cycle the per-pair counting rules: single-step advance when running and gated open, hold when either the pair or the global window is closed, event increment only on a stopped-to-running start, zeroing on a clear, all pairs stopped after a global clear, and zero read data for unused words. What only the bench scenarios show is the offset decoding as software sees it: that a non-zero value to a start offset is ignored, that clearing one section leaves the others intact, that exact cycle totals accumulate across several windows, and that writes to unused or out-of-range offsets leave every readable count unchanged.

// File: rtl/perf_pkg.sv
package perf_pkg;
  localparam int unsigned CYC_W  = 64;
  localparam int unsigned EVT_W  = 32;
  localparam int unsigned WORD_W = 32;

  // word slot inside a four-word pair group; decode depends on this order
  typedef enum logic [1:0] {
    SLOT_CTRL  = 2'd0,
    SLOT_START = 2'd1,
    SLOT_EVT   = 2'd2,
    SLOT_NONE  = 2'd3
  } slot_e;
endpackage

// File: rtl/perf_cmd_dec.sv
module perf_cmd_dec
  import perf_pkg::*;
#(
  parameter int unsigned N_PAIR = 4,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [N_PAIR-1:0] start_o,
  output logic [N_PAIR-1:0] stop_o,
  output logic [N_PAIR-1:0] clr_o
);
  localparam int unsigned PIDX_W = ADDR_W - 2;

  logic [PIDX_W-1:0] pidx;
  slot_e             slot;
  logic              glob_clr;

  assign pidx = addr_i[ADDR_W-1:2];
  assign slot = slot_e'(addr_i[1:0]);

  assign glob_clr = wr_en_i && (pidx == '0) && (slot == SLOT_CTRL) && wdata_i[0];

  for (genvar i = 0; i < N_PAIR; i++) begin : g_pair
    logic hit;
    assign hit        = wr_en_i && (pidx == PIDX_W'(i));
    assign start_o[i] = hit && (slot == SLOT_START) && (wdata_i == '0);
    assign stop_o[i]  = hit && (slot == SLOT_CTRL) && !wdata_i[0];
    // a global clear fans out to every pair
    assign clr_o[i]   = (hit && (slot == SLOT_CTRL) && wdata_i[0]) || glob_clr;
  end
endmodule

// File: rtl/perf_pair.sv
module perf_pair
  import perf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gate_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             clr_i,
  output logic             run_o,
  output logic [CYC_W-1:0] cyc_o,
  output logic [EVT_W-1:0] evt_o
);
  logic             run_q;
  logic [CYC_W-1:0] cyc_q;
  logic [EVT_W-1:0] evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cyc_q <= '0;
      evt_q <= '0;
    end else if (clr_i) begin
      run_q <= 1'b0;
      cyc_q <= '0;
      evt_q <= '0;
    end else begin
      if (run_q && gate_i) cyc_q <= cyc_q + CYC_W'(1);
      if (start_i && !run_q) begin
        run_q <= 1'b1;
        evt_q <= evt_q + EVT_W'(1);
      end else if (stop_i) begin
        run_q <= 1'b0;
      end
    end
  end

  assign run_o = run_q;
  assign cyc_o = cyc_q;
  assign evt_o = evt_q;

  AST_CYC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && gate_i && !clr_i) |=> (cyc_q == $past(cyc_q) + CYC_W'(1))); // R4
  AST_GATED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(run_q && gate_i) && !clr_i) |=> $stable(cyc_q)); // R5
  AST_EVT_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !run_q && !clr_i) |=> (run_q && evt_q == $past(evt_q) + EVT_W'(1))); // R6
  AST_START_WHILE_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && run_q && !clr_i) |=> $stable(evt_q)); // R6
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cyc_q == '0 && evt_q == '0 && !run_q)); // R8
endmodule

// File: rtl/perf_rd_mux.sv
module perf_rd_mux
  import perf_pkg::*;
#(
  parameter int unsigned N_PAIR = 4,
  parameter int unsigned ADDR_W = 5
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         rd_en_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [N_PAIR-1:0][CYC_W-1:0] cyc_i,
  input  logic [N_PAIR-1:0][EVT_W-1:0] evt_i,
  output logic [WORD_W-1:0]            rdata_o
);
  localparam int unsigned PIDX_W = ADDR_W - 2;

  logic [PIDX_W-1:0] pidx;
  slot_e             slot;
  logic [WORD_W-1:0] rd_nxt;
  logic [WORD_W-1:0] rdata_q;

  assign pidx = addr_i[ADDR_W-1:2];
  assign slot = slot_e'(addr_i[1:0]);

  always_comb begin
    rd_nxt = '0;
    for (int i = 0; i < N_PAIR; i++) begin
      if (pidx == PIDX_W'(i)) begin
        case (slot)
          SLOT_CTRL:  rd_nxt = cyc_i[i][WORD_W-1:0];
          SLOT_START: rd_nxt = cyc_i[i][CYC_W-1:CYC_W-WORD_W];
          SLOT_EVT:   rd_nxt = WORD_W'(evt_i[i]);
          default:    rd_nxt = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_nxt;
  end

  assign rdata_o = rdata_q;

  AST_RD_UNUSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (slot == SLOT_NONE || 32'(pidx) >= N_PAIR)) |=> (rdata_o == '0)); // R10
  AST_RD_GLOBAL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && pidx == '0 && slot == SLOT_CTRL) |=> (rdata_o == $past(cyc_i[0][WORD_W-1:0]))); // R9
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o)); // R9
endmodule

// File: rtl/perf_section_counter.sv
module perf_section_counter
  import perf_pkg::*;
#(
  parameter int unsigned N_SECT = 3,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int unsigned N_PAIR = N_SECT + 1;

  logic [N_PAIR-1:0]            start_w;
  logic [N_PAIR-1:0]            stop_w;
  logic [N_PAIR-1:0]            clr_w;
  logic [N_PAIR-1:0]            run_w;
  logic [N_PAIR-1:0]            gate_w;
  logic [N_PAIR-1:0][CYC_W-1:0] cyc_w;
  logic [N_PAIR-1:0][EVT_W-1:0] evt_w;

  perf_cmd_dec #(.N_PAIR(N_PAIR), .ADDR_W(ADDR_W)) u_dec (
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .start_o (start_w),
    .stop_o  (stop_w),
    .clr_o   (clr_w)
  );

  for (genvar i = 0; i < N_PAIR; i++) begin : g_pair
    if (i == 0) begin : g_glob
      assign gate_w[i] = 1'b1;
    end else begin : g_sect
      assign gate_w[i] = run_w[0];  // sections count only inside the global window
    end

    perf_pair u_pair (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .gate_i  (gate_w[i]),
      .start_i (start_w[i]),
      .stop_i  (stop_w[i]),
      .clr_i   (clr_w[i]),
      .run_o   (run_w[i]),
      .cyc_o   (cyc_w[i]),
      .evt_o   (evt_w[i])
    );
  end

  perf_rd_mux #(.N_PAIR(N_PAIR), .ADDR_W(ADDR_W)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .cyc_i   (cyc_w),
    .evt_i   (evt_w),
    .rdata_o (rdata_o)
  );

  AST_GCLR_STOPS_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&clr_w) |=> (run_w == '0)); // R7
  AST_RESET_STATE: assert property (@(posedge clk_i)
    !rst_ni |-> (run_w == '0 && rdata_o == '0)); // R1
endmodule

// File: tb/sim_perf_section_counter.sv
`timescale 1ns/1ps
module sim_perf_section_counter;
  localparam int N_SECT = 3;
  localparam int ADDR_W = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;

  int checks = 0;
  int failures = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;
  bit          done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  perf_section_counter #(.N_SECT(N_SECT), .ADDR_W(ADDR_W)) u0 (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .wr_en_i (wr_en),
    .rd_en_i (rd_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata)
  );

  // monitor: compare each read result one cycle after its strobe
  always @(posedge clk) rd_seen <= rd_en;

  always @(negedge clk) begin : mon
    logic [31:0] e;
    string t;
    if (rd_seen && exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        failures++;
        $display("FAIL %s: rdata=%0d expected %0d", t, rdata, e);
      end
    end
  end

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string t);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rdata !== 32'd0) begin
      failures++;
      $display("FAIL R1: rdata=%0d expected 0 in reset", rdata);
    end
    rst_n = 1'b1;
    idle(1);
    rd(0, 0, "R1 glob cyc lo");
    rd(1, 0, "R1 glob cyc hi");
    rd(2, 0, "R1 glob evt");
    rd(6, 0, "R1 sect1 evt");

    // global window of 10 cycles
    wr(1, 0); idle(9); wr(0, 0);
    idle(5);
    rd(0, 10, "R4 glob cyc after window");
    rd(0, 10, "R3 glob cyc holds after stop");
    rd(1, 0, "R9 glob cyc hi");
    rd(2, 1, "R6 glob evt first start");

    // section 1 running while global stopped
    wr(5, 0); idle(5);
    rd(4, 0, "R5 sect1 gated by global");
    rd(6, 1, "R6 sect1 evt");

    wr(1, 0); idle(4); wr(4, 0); wr(0, 0);
    rd(4, 5, "R5 sect1 inside window");
    rd(0, 16, "R4 glob cyc accumulates");
    rd(2, 2, "R6 glob evt second start");

    // start while running
    wr(1, 0); wr(1, 0); wr(0, 0);
    rd(0, 18, "R4 glob cyc after double start");
    rd(2, 3, "R6 start while running ignored");

    // non-zero start value
    wr(1, 5); idle(3);
    rd(0, 18, "R2 nonzero start ignored cyc");
    rd(2, 3, "R2 nonzero start ignored evt");

    // unused and out-of-range offsets
    wr(17, 0); wr(3, 1); wr(2, 0); wr(19, 1); wr(16, 1);
    rd(17, 0, "R10 beyond sections hi");
    rd(16, 0, "R10 beyond sections lo");
    rd(3, 0, "R10 unused word glob");
    rd(7, 0, "R10 unused word sect1");
    rd(18, 0, "R10 beyond sections evt");
    rd(0, 18, "R10 writes had no effect cyc");
    rd(2, 3, "R10 writes had no effect evt");

    // section clear isolation
    wr(9, 0); wr(1, 0); idle(2); wr(0, 0);
    wr(4, 1);
    rd(4, 0, "R8 sect1 cyc cleared");
    rd(6, 0, "R8 sect1 evt cleared");
    rd(8, 3, "R8 sect2 cyc untouched");
    rd(10, 1, "R8 sect2 evt untouched");
    rd(0, 21, "R8 glob cyc untouched");
    rd(2, 4, "R8 glob evt untouched");

    wr(8, 1); wr(1, 0); idle(1); wr(0, 0);
    rd(8, 0, "R8 cleared sect stays stopped");
    rd(10, 0, "R8 sect2 evt cleared");
    rd(0, 23, "R4 glob cyc after third window");
    rd(2, 5, "R6 glob evt fifth start");

    // global clear
    wr(5, 0); wr(1, 0); idle(2); wr(0, 1); idle(3);
    rd(0, 0, "R7 glob cyc lo cleared");
    rd(1, 0, "R7 glob cyc hi cleared");
    rd(2, 0, "R7 glob evt cleared");
    rd(4, 0, "R7 sect1 cyc cleared");
    rd(6, 0, "R7 sect1 evt cleared");
    rd(8, 0, "R7 sect2 cyc cleared");
    wr(1, 0); wr(0, 0);
    rd(0, 1, "R7 glob restarts from zero");
    rd(2, 1, "R7 glob evt restarts");
    rd(4, 0, "R7 sect1 left stopped");
    rd(6, 0, "R7 sect1 evt stays zero");

    idle(3);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    finish_run();
  end
endmodule